// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block produces six gate-drive signals for a three-phase bridge: for each of the three legs a high-side and a low-side output. A center-aligned carrier, counting up to a 16-bit modulus and back down, is compared against one duty value per leg. Each comparison becomes a complementary pair, with a programmable dead band inserted before every turn-on edge. A per-side polarity setting is then applied to the pair.

Polarity and dead time are each accepted once after reset. Until both have been loaded the output enable stays low, so the pads are meant to float. Once enabled, the block first runs a pre-charge phase in which only the low-side switches conduct. It then raises the energized flag and starts normal switching. An asynchronous kill input drops every output to its inactive level at once. Period and duty changes are taken only at the carrier valley.

Top module: `pwm3_gen`

## Requirements
- R1: After reset `oe_o`=0 and `pwm_o`=0. `oe_o` rises one cycle after the later of the two first writes, polarity and dead time. Either write alone leaves `oe_o` at 0, and `oe_o` never falls again until reset.
- R2: Polarity and dead time are write-once. Any later write leaves the stored value unchanged and pulses `cfg_err_o` high for exactly one cycle, the cycle after the write.
- R3: `pol_i[0]`=1 inverts the high-side outputs and `pol_i[1]`=1 inverts the low-side outputs. `pwm_o[2k]` is the high side of leg k and `pwm_o[2k+1]` is its low side, with legs k=0,1,2.
- R4: For `PRECHG_CYC` cycles after `oe_o` rises, every high side is inactive, every low side is active, and `energized_o`=0. `energized_o` rises exactly `PRECHG_CYC` cycles after `oe_o` and is never 1 while `oe_o` is 0.
- R5: The carrier counts 0,1,…,M,…,1 with one step per tick, so the switching period is 2·M ticks for modulus M.
- R6: With duty d (0<d≤M) and dead time D, the high side of a leg is active for 2d−1−D ticks per period and the low side for 2M−2d+1−D ticks. A tick is one clock when `TICK_DIV`=1, and duty d is taken from `duty_i[16k +: 16]`.
- R7: At every transition both outputs of a leg are inactive for exactly D ticks, and the two are never active together.
- R8: New `period_i` and `duty_i` values are taken only when the carrier is at zero. A change made in mid-period leaves the current period's length unchanged.
- R9: `kill_i`=1 drives all six outputs to their inactive level and `energized_o` to 0 in the same cycle, with no clock edge needed.
- R10: Duty 0 keeps the high side permanently off and the low side permanently on. A duty above M keeps the high side permanently on and the low side off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | 16 | Carrier modulus M |
| duty_i | input | 48 | Duty per leg, leg k in bits [16k+15:16k] |
| pol_wr_i | input | 1 | Polarity write strobe |
| pol_i | input | 2 | Polarity: bit 0 inverts high sides, bit 1 inverts low sides |
| dt_wr_i | input | 1 | Dead-time write strobe |
| dt_i | input | 8 | Dead time in ticks |
| kill_i | input | 1 | Asynchronous disable |
| pwm_o | output | 6 | Gate outputs, high side at even index |
| oe_o | output | 1 | Output enable; pads float while low |
| energized_o | output | 1 | All outputs switching normally |
| cfg_err_o | output | 1 | One-cycle pulse on a rejected write |

## Verification
The output enable and the rejected-write pulse both appear one cycle after the write strobe is taken. The bench therefore drives each strobe at a falling edge and checks at the next falling edge. The energized flag is probed at `PRECHG_CYC`−1 and at `PRECHG_CYC` falling edges after the enable, so that the exact edge is fixed. Kill is checked one time unit after it is driven, before any clock edge. Duty, period and dead-band results only settle after a carrier valley, so the bench waits several periods and then counts active levels over windows that are an exact multiple of 2·M. For the reload case, the period change is placed just after a high-side fall, which lies past the valley, and the spacing of the rising edges on each side of the change is compared.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int unsigned NPH = 3;

  typedef struct packed {
    logic bot_inv;
    logic top_inv;
  } pol_t;
endpackage

// File: rtl/pwm3_cfg.sv
module pwm3_cfg import pwm3_pkg::*; #(
  parameter int unsigned DW         = 8,
  parameter int unsigned PRECHG_CYC = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pol_wr_i,
  input  logic [1:0]    pol_i,
  input  logic          dt_wr_i,
  input  logic [DW-1:0] dt_i,
  output pol_t          pol_o,
  output logic [DW-1:0] dt_o,
  output logic          oe_o,
  output logic          run_o,
  output logic          err_o
);
  localparam int unsigned PCW = $clog2(PRECHG_CYC + 1);

  logic          pol_set_q, dt_set_q, run_q, err_q;
  pol_t          pol_q;
  logic [DW-1:0] dt_q;
  logic [PCW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_set_q <= 1'b0;
      dt_set_q  <= 1'b0;
      run_q     <= 1'b0;
      err_q     <= 1'b0;
      pol_q     <= '0;
      dt_q      <= '0;
      pc_q      <= '0;
    end else begin
      err_q <= (pol_wr_i && pol_set_q) || (dt_wr_i && dt_set_q);
      if (pol_wr_i && !pol_set_q) begin
        pol_q     <= pol_t'(pol_i);
        pol_set_q <= 1'b1;
      end
      if (dt_wr_i && !dt_set_q) begin
        dt_q     <= dt_i;
        dt_set_q <= 1'b1;
      end
      // pre-charge: low sides only, then release
      if (pol_set_q && dt_set_q && !run_q) begin
        if (pc_q == PCW'(PRECHG_CYC - 1)) run_q <= 1'b1;
        pc_q <= pc_q + PCW'(1);
      end
    end
  end

  assign pol_o = pol_q;
  assign dt_o  = dt_q;
  assign oe_o  = pol_set_q && dt_set_q;
  assign run_o = run_q;
  assign err_o = err_q;
endmodule

// File: rtl/pwm3_carrier.sv
module pwm3_carrier import pwm3_pkg::*; #(
  parameter int unsigned CW       = 16,
  parameter int unsigned TICK_DIV = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     period_i,
  input  logic [NPH*CW-1:0] duty_i,
  output logic              tick_o,
  output logic [NPH-1:0]    ref_o
);
  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int unsigned DVW = $clog2(TICK_DIV);
      logic [DVW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           div_q <= '0;
        else if (div_q == DVW'(TICK_DIV - 1))  div_q <= '0;
        else                                   div_q <= div_q + DVW'(1);
      end
      assign tick_o = (div_q == DVW'(TICK_DIV - 1));
    end else begin : g_nodiv
      assign tick_o = 1'b1;
    end
  endgenerate

  logic [CW-1:0]          cnt_q, per_q;
  logic                   up_q;
  logic [NPH-1:0][CW-1:0] duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= '0;
      up_q   <= 1'b1;
      duty_q <= '0;
    end else if (tick_o) begin
      if (cnt_q == '0) begin
        // valley: shadow reload point
        per_q  <= period_i;
        duty_q <= duty_i;
        cnt_q  <= CW'(1);
        up_q   <= 1'b1;
      end else if (up_q && cnt_q >= per_q) begin
        cnt_q <= cnt_q - CW'(1);
        up_q  <= 1'b0;
      end else if (up_q) begin
        cnt_q <= cnt_q + CW'(1);
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NPH; k++) ref_o[k] = (cnt_q < duty_q[k]);
  end
endmodule

// File: rtl/pwm3_deadband.sv
module pwm3_deadband #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ref_i,
  input  logic [DW-1:0] dt_i,
  output logic          top_o,
  output logic          bot_o
);
  logic          ref_q;
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      cnt_q <= '0;
    end else if (tick_i) begin
      ref_q <= ref_i;
      if (ref_i != ref_q)    cnt_q <= dt_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - DW'(1);
    end
  end

  assign top_o = ref_q  && (cnt_q == '0);
  assign bot_o = !ref_q && (cnt_q == '0);
endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen import pwm3_pkg::*; #(
  parameter int unsigned CW         = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned TICK_DIV   = 1,
  parameter int unsigned PRECHG_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     period_i,
  input  logic [NPH*CW-1:0] duty_i,
  input  logic              pol_wr_i,
  input  logic [1:0]        pol_i,
  input  logic              dt_wr_i,
  input  logic [DW-1:0]     dt_i,
  input  logic              kill_i,
  output logic [2*NPH-1:0]  pwm_o,
  output logic              oe_o,
  output logic              energized_o,
  output logic              cfg_err_o
);
  logic           tick, oe, run, err;
  logic [NPH-1:0] ref_s, top_s, bot_s, act_top, act_bot;
  pol_t           pol;
  logic [DW-1:0]  dt;

  pwm3_cfg #(.DW(DW), .PRECHG_CYC(PRECHG_CYC)) u_cfg (
    .clk_i, .rst_ni, .pol_wr_i, .pol_i, .dt_wr_i, .dt_i,
    .pol_o(pol), .dt_o(dt), .oe_o(oe), .run_o(run), .err_o(err)
  );

  pwm3_carrier #(.CW(CW), .TICK_DIV(TICK_DIV)) u_carrier (
    .clk_i, .rst_ni, .period_i, .duty_i, .tick_o(tick), .ref_o(ref_s)
  );

  generate
    for (genvar k = 0; k < NPH; k++) begin : g_leg
      pwm3_deadband #(.DW(DW)) u_db (
        .clk_i, .rst_ni, .tick_i(tick), .ref_i(ref_s[k]), .dt_i(dt),
        .top_o(top_s[k]), .bot_o(bot_s[k])
      );
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < NPH; k++) begin
      act_top[k]     = run && top_s[k] && !kill_i;
      act_bot[k]     = (run ? bot_s[k] : 1'b1) && !kill_i;
      pwm_o[2*k]     = oe && (act_top[k] ^ pol.top_inv);
      pwm_o[2*k + 1] = oe && (act_bot[k] ^ pol.bot_inv);
    end
  end

  assign oe_o        = oe;
  assign energized_o = run && !kill_i;
  assign cfg_err_o   = err;
endmodule

// File: rtl/pwm3_gen_chk.sv
module pwm3_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pol_wr_i,
  input logic       dt_wr_i,
  input logic       kill_i,
  input logic [5:0] pwm_o,
  input logic       oe_o,
  input logic       energized_o,
  input logic       cfg_err_o,
  input logic [1:0] pol_q_i
);
  logic [5:0] act;
  assign act = pwm_o ^ {3{pol_q_i[1], pol_q_i[0]}};

  p_oe_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(pol_wr_i || dt_wr_i));
  p_oe_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |=> oe_o);
  p_err_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(pol_wr_i || dt_wr_i));
  p_pol_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |=> $stable(pol_q_i));
  p_energized_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    energized_o |-> oe_o);
  p_prechg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !energized_o && !kill_i) |-> (act == 6'b101010));
  p_kill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_i && oe_o) |-> (act == 6'b000000 && !energized_o));

  generate
    for (genvar k = 0; k < 3; k++) begin : g_leg
      p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_o |-> !(act[2*k] && act[2*k+1]));
    end
  endgenerate
endmodule

bind pwm3_gen pwm3_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pol_wr_i(pol_wr_i), .dt_wr_i(dt_wr_i),
  .kill_i(kill_i), .pwm_o(pwm_o), .oe_o(oe_o), .energized_o(energized_o),
  .cfg_err_o(cfg_err_o), .pol_q_i(pol)
);

// File: tb/pwm3_gen_bench.sv
`timescale 1ns/1ps
module pwm3_gen_bench;
  localparam int PRE = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] period_i = 16'd40;
  logic [47:0] duty_i = {16'd30, 16'd20, 16'd10};
  logic        pol_wr_i = 1'b0, dt_wr_i = 1'b0, kill_i = 1'b0;
  logic [1:0]  pol_i = 2'b00;
  logic [7:0]  dt_i = 8'd0;
  logic [5:0]  pwm_o;
  logic        oe_o, energized_o, cfg_err_o;

  int checks = 0, failures = 0, cyc = 0;
  logic [5:0] mask = 6'b010101; // inactive levels for polarity 01
  bit done = 0;

  pwm3_gen #(.TICK_DIV(1), .PRECHG_CYC(PRE)) u_pwm3_gen (.*);

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic measure(input int k, input int n, output int nt, output int nb, output int nz);
    logic [5:0] a;
    nt = 0; nb = 0; nz = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      a = pwm_o ^ mask;
      if (a[2*k]) nt++;
      if (a[2*k+1]) nb++;
      if (!a[2*k] && !a[2*k+1]) nz++;
    end
  endtask

  task automatic wait_top(input int k, input logic lvl, output int t);
    logic prev, cur;
    prev = (pwm_o[2*k] ^ mask[2*k]);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk_i);
      cur = (pwm_o[2*k] ^ mask[2*k]);
      if (cur == lvl && prev != lvl) begin t = cyc; return; end
      prev = cur;
    end
    t = -1;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1", "oe after reset", oe_o, 0);
    chk("R1", "pwm after reset", pwm_o, 0);
    chk("R4", "energized after reset", energized_o, 0);
    chk("R2", "err after reset", cfg_err_o, 0);
  endtask

  task automatic t_pol_only();
    pol_wr_i = 1'b1; pol_i = 2'b01;
    @(negedge clk_i); pol_wr_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R1", "oe with polarity only", oe_o, 0);
    chk("R2", "no err on first write", cfg_err_o, 0);
  endtask

  task automatic t_dt_prechg();
    dt_wr_i = 1'b1; dt_i = 8'd3;
    @(negedge clk_i); dt_wr_i = 1'b0;
    chk("R1", "oe after both written", oe_o, 1);
    chk("R4", "energized at precharge start", energized_o, 0);
    chk("R4", "precharge levels", pwm_o ^ mask, 6'b101010);
    repeat (PRE - 1) @(negedge clk_i);
    chk("R4", "energized at PRE-1", energized_o, 0);
    chk("R4", "precharge levels late", pwm_o ^ mask, 6'b101010);
    @(negedge clk_i);
    chk("R4", "energized at PRE", energized_o, 1);
  endtask

  task automatic t_once_kill();
    pol_wr_i = 1'b1; pol_i = 2'b10; dt_wr_i = 1'b1; dt_i = 8'd7;
    @(negedge clk_i); pol_wr_i = 1'b0; dt_wr_i = 1'b0;
    chk("R2", "err pulse", cfg_err_o, 1);
    @(negedge clk_i);
    chk("R2", "err pulse end", cfg_err_o, 0);
    #1 kill_i = 1'b1;
    #1;
    chk("R2", "polarity kept (R3 inactive levels)", pwm_o, 6'b010101);
    chk("R9", "energized under kill", energized_o, 0);
    chk("R1", "oe stays under kill", oe_o, 1);
    @(negedge clk_i); kill_i = 1'b0;
    #1 chk("R9", "energized after kill release", energized_o, 1);
  endtask

  task automatic t_duty();
    int nt, nb, nz;
    int d[3] = '{10, 20, 30};
    repeat (240) @(negedge clk_i);
    for (int k = 0; k < 3; k++) begin
      measure(k, 80, nt, nb, nz);
      chk("R6", $sformatf("high-side ticks leg %0d", k), nt, 2*d[k]-1-3);
      chk("R6", $sformatf("low-side ticks leg %0d", k), nb, 80-2*d[k]+1-3);
      chk("R7", $sformatf("dead ticks leg %0d (R2 dt kept)", k), nz, 6);
    end
  endtask

  task automatic t_period_reload();
    int a, b, c, f;
    wait_top(0, 1'b1, a);
    wait_top(0, 1'b0, f);
    period_i = 16'd50;
    wait_top(0, 1'b1, b);
    chk("R5", "period before change 2M", b - a, 80);
    wait_top(0, 1'b1, c);
    chk("R8", "new period after valley", c - b, 100);
  endtask

  task automatic t_extremes();
    int nt, nb, nz;
    duty_i = {16'd25, 16'd60, 16'd0};
    repeat (300) @(negedge clk_i);
    measure(0, 100, nt, nb, nz);
    chk("R10", "duty 0 high side", nt, 0);
    chk("R10", "duty 0 low side", nb, 100);
    measure(1, 100, nt, nb, nz);
    chk("R10", "duty>M high side", nt, 100);
    chk("R10", "duty>M low side", nb, 0);
    measure(2, 100, nt, nb, nz);
    chk("R6", "high-side ticks M=50", nt, 46);
    chk("R7", "dead ticks M=50", nz, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_pol_only();
    t_dt_prechg();
    t_once_kill();
    t_duty();
    t_period_reload();
    t_extremes();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule